// File: doc/BRIEF.md
# Streaming Triple Product Pipeline

This block takes a stream of operand triples (a, b, c) and returns the product a*b*c, one result per triple and in arrival order. Two pipelined integer multipliers do the work. Each has a fixed latency and takes a new operand pair every cycle. The first multiplier forms a*b. While that product is in flight, c waits in a forwarding FIFO. When the first product comes out, the FIFO head is popped and both values go into the second multiplier.

The forwarding path is a FIFO, not a delay line matched to the latency. Results are therefore correct for any FIFO depth. A FIFO at least as deep as the multiplier latency sustains one triple per cycle. A shallower FIFO of depth L reaches L triples every latency-period of cycles.

Results collect in an output buffer. A credit count holds the number of triples in flight to what that buffer can hold, so stalling the consumer never drops a result. Both ends use valid/ready handshakes.

Top module: `triple_product_pipe`

## Requirements
- R1: Each triple accepted at the input (in_valid and in_ready high at a rising edge) yields exactly one result, out_data = (a*b*c) truncated to the low DATA_W bits.
- R2: Results leave in the order their triples were accepted. No result is lost or duplicated, even when out_ready is low for long stretches.
- R3: With an empty pipeline and out_ready high, out_valid first goes high after 2*MUL_LAT+1 rising edges, counting the edge that accepts the triple.
- R4: With FWD_DEPTH >= MUL_LAT, in_valid held high and out_ready held high, one triple is accepted in every cycle in steady state.
- R5: With FWD_DEPTH = L < MUL_LAT and the same stimulus, exactly L triples are accepted in every MUL_LAT consecutive cycles in steady state, and every result stays correct.
- R6: in_ready is low while the forwarding FIFO is full, unless a first-stage product leaves in that same cycle. The forwarding FIFO never overflows.
- R7: At most 2*MUL_LAT+2 triples are in flight (accepted but not yet taken at the output). Once that limit is reached, in_ready is low. While out_valid is high and out_ready is low, out_valid stays high and out_data holds its value.
- R8: After reset, out_valid is low and in_ready is high.
- R9: The forwarding FIFO is popped exactly when a first-stage product leaves the first multiplier, and it is never empty at that moment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input triple present |
| in_ready | output | 1 | Block can accept a triple this cycle |
| in_a | input | DATA_W | First operand |
| in_b | input | DATA_W | Second operand |
| in_c | input | DATA_W | Third operand, forwarded through the FIFO |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | DATA_W | Truncated product a*b*c |

## Verification
The bench builds two copies of the block, both with DATA_W=32 and MUL_LAT=7. One has FWD_DEPTH=7 and the other FWD_DEPTH=3. The deep copy reaches the full one-per-cycle rate, the exact first-result latency and the credit ceiling under a stalled consumer. The shallow copy reaches the depth-over-latency throughput regime, where the FIFO and not the multipliers sets the pace, and shows that results stay correct there. Random operands and handshakes are mixed with all-ones, zero and overflowing operands.

// File: rtl/tpp_pkg.sv
package tpp_pkg;
   // Pointer width for a storage of the given depth (at least one bit).
   function automatic int unsigned ptr_w(int unsigned depth);
      return (depth > 1) ? $clog2(depth) : 1;
   endfunction

   // Width of a counter that must reach the value n inclusive.
   function automatic int unsigned cnt_w(int unsigned n);
      return $clog2(n + 1);
   endfunction
endpackage

// File: rtl/tpp_mul_pipe.sv
module tpp_mul_pipe #(
   parameter int unsigned W   = 32,
   parameter int unsigned LAT = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_vld,
   input  logic [W-1:0] in_x,
   input  logic [W-1:0] in_y,
   output logic         out_vld,
   output logic [W-1:0] out_p
);
   generate
      if (LAT < 1) begin : g_bad_lat
         $error("tpp_mul_pipe: LAT must be at least 1");
      end
   endgenerate

   logic [W-1:0] stg [LAT];
   logic [LAT-1:0] vld;

   always_ff @(posedge clk) begin
      stg[0] <= in_x * in_y;
   end

   generate
      for (genvar i = 1; i < LAT; i++) begin : g_stage
         always_ff @(posedge clk) begin
            stg[i] <= stg[i-1];
         end
      end

      if (LAT == 1) begin : g_vld_single
         always_ff @(posedge clk) begin
            if (!rst_n) vld <= '0;
            else        vld <= in_vld;
         end
      end else begin : g_vld_chain
         always_ff @(posedge clk) begin
            if (!rst_n) vld <= '0;
            else        vld <= {vld[LAT-2:0], in_vld};
         end
      end
   endgenerate

   assign out_vld = vld[LAT-1];
   assign out_p   = stg[LAT-1];
endmodule

// File: rtl/tpp_fifo.sv
module tpp_fifo #(
   parameter int unsigned W     = 32,
   parameter int unsigned DEPTH = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   localparam int unsigned PW = tpp_pkg::ptr_w(DEPTH);
   localparam int unsigned CW = tpp_pkg::cnt_w(DEPTH);

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("tpp_fifo: DEPTH must be at least 1");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr;
   logic [CW-1:0] cnt;

   assign empty = (cnt == '0);
   assign full  = (cnt == CW'(DEPTH));
   assign dout  = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         if (pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
         cnt <= cnt + CW'(push) - CW'(pop);
      end
   end

   // R6 / R7: a push into a full store is only legal alongside a pop.
   assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      push && full |-> pop);
   // R9: never pop an empty store.
   assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
endmodule

// File: rtl/triple_product_pipe.sv
module triple_product_pipe #(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned MUL_LAT   = 7,
   parameter int unsigned FWD_DEPTH = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_a,
   input  logic [DATA_W-1:0] in_b,
   input  logic [DATA_W-1:0] in_c,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data
);
   localparam int unsigned CREDITS = 2 * MUL_LAT + 2;
   localparam int unsigned FW      = tpp_pkg::cnt_w(CREDITS);

   generate
      if (DATA_W < 1 || FWD_DEPTH < 1 || MUL_LAT < 1) begin : g_bad_cfg
         $error("triple_product_pipe: DATA_W, MUL_LAT and FWD_DEPTH must be positive");
      end
   endgenerate

   logic              accept, out_pop;
   logic              m1_vld, m2_vld;
   logic [DATA_W-1:0] m1_p, m2_p, c_head;
   logic              fwd_empty, fwd_full, res_empty, res_full;
   logic [FW-1:0]     inflight;

   assign in_ready  = (!fwd_full || m1_vld) && (inflight < FW'(CREDITS));
   assign accept    = in_valid && in_ready;
   assign out_valid = !res_empty;
   assign out_pop   = out_valid && out_ready;

   tpp_mul_pipe #(.W(DATA_W), .LAT(MUL_LAT)) u_mul_ab (
      .clk(clk), .rst_n(rst_n), .in_vld(accept), .in_x(in_a), .in_y(in_b),
      .out_vld(m1_vld), .out_p(m1_p));

   tpp_fifo #(.W(DATA_W), .DEPTH(FWD_DEPTH)) u_fwd_c (
      .clk(clk), .rst_n(rst_n), .push(accept), .din(in_c), .pop(m1_vld),
      .dout(c_head), .empty(fwd_empty), .full(fwd_full));

   tpp_mul_pipe #(.W(DATA_W), .LAT(MUL_LAT)) u_mul_abc (
      .clk(clk), .rst_n(rst_n), .in_vld(m1_vld), .in_x(m1_p), .in_y(c_head),
      .out_vld(m2_vld), .out_p(m2_p));

   tpp_fifo #(.W(DATA_W), .DEPTH(CREDITS)) u_result (
      .clk(clk), .rst_n(rst_n), .push(m2_vld), .din(m2_p), .pop(out_pop),
      .dout(out_data), .empty(res_empty), .full(res_full));

   always_ff @(posedge clk) begin
      if (!rst_n) inflight <= '0;
      else        inflight <= inflight + FW'(accept) - FW'(out_pop);
   end

   // R7: the credit count never passes the result buffer size.
   assert_credit_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      inflight <= FW'(CREDITS));
   // R7: a stalled result is held.
   assert_out_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data));
   // R9: every first-stage product finds its forwarded operand.
   assert_fwd_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
      m1_vld |-> !fwd_empty);
   // R2: a finished product always has room in the result buffer.
   assert_result_room_R2: assert property (@(posedge clk) disable iff (!rst_n)
      m2_vld |-> !res_full || out_pop);
endmodule

// File: tb/triple_product_pipe_bench.sv
module triple_product_pipe_bench;
   localparam int unsigned CLK_PERIOD = 10;
   localparam int unsigned W    = 32;
   localparam int unsigned LAT  = 7;
   localparam int unsigned SHORT = 3;
   localparam int unsigned CRED = 2 * LAT + 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   logic         sel = 1'b0;   // 0: deep copy, 1: shallow copy
   logic         drv_valid = 1'b0, drv_ready = 1'b1;
   logic [W-1:0] drv_a = '0, drv_b = '0, drv_c = '0;
   logic         rdy_d, rdy_s, ov_d, ov_s;
   logic [W-1:0] od_d, od_s;

   triple_product_pipe #(.DATA_W(W), .MUL_LAT(LAT), .FWD_DEPTH(LAT)) u_triple_product_pipe (
      .clk(clk), .rst_n(rst_n), .in_valid(drv_valid && !sel), .in_ready(rdy_d),
      .in_a(drv_a), .in_b(drv_b), .in_c(drv_c),
      .out_valid(ov_d), .out_ready(drv_ready), .out_data(od_d));

   triple_product_pipe #(.DATA_W(W), .MUL_LAT(LAT), .FWD_DEPTH(SHORT)) u_triple_product_pipe_short (
      .clk(clk), .rst_n(rst_n), .in_valid(drv_valid && sel), .in_ready(rdy_s),
      .in_a(drv_a), .in_b(drv_b), .in_c(drv_c),
      .out_valid(ov_s), .out_ready(drv_ready), .out_data(od_s));

   int errors = 0, checks = 0, accepts = 0;
   bit done = 1'b0;
   logic [W-1:0] expq[$];
   logic         seen_ov;
   logic [W-1:0] held;
   bit           stall_track = 1'b0;

   function automatic logic [W-1:0] model(logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c);
      logic [W-1:0] ab;
      ab = a * b;
      return ab * c;
   endfunction

   task automatic check(bit ok, string tag, longint act, longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // One cycle: sample after inputs settle, then advance to the next falling edge.
   task automatic step();
      logic rdy, ov;
      logic [W-1:0] od;
      #1;
      rdy = sel ? rdy_s : rdy_d;
      ov  = sel ? ov_s  : ov_d;
      od  = sel ? od_s  : od_d;
      seen_ov = ov;
      if (stall_track && ov)
         check(od == held, "R7 held data", od, held);
      if (ov && !drv_ready) begin
         held = od;
         stall_track = 1'b1;
      end else stall_track = 1'b0;
      if (drv_valid && rdy) begin
         expq.push_back(model(drv_a, drv_b, drv_c));
         accepts++;
      end
      if (ov && drv_ready) begin
         if (expq.size() == 0) check(1'b0, "R2 unexpected result", od, 0);
         else begin
            logic [W-1:0] e;
            e = expq.pop_front();
            check(od == e, "R1 R2 result", od, e);
         end
      end
      @(negedge clk);
   endtask

   task automatic rand_data();
      drv_a = $urandom; drv_b = $urandom; drv_c = $urandom;
   endtask

   task automatic drain();
      drv_valid = 1'b0; drv_ready = 1'b1;
      for (int i = 0; i < 60; i++) step();
      check(expq.size() == 0, "R2 all results delivered", expq.size(), 0);
   endtask

   task automatic throughput(int exp_in_70, string tag);
      drv_valid = 1'b1; drv_ready = 1'b1;
      for (int i = 0; i < 40; i++) begin rand_data(); step(); end
      accepts = 0;
      for (int i = 0; i < 70; i++) begin rand_data(); step(); end
      check(accepts == exp_in_70, tag, accepts, exp_in_70);
      drain();
   endtask

   task automatic random_run(int n);
      for (int i = 0; i < n; i++) begin
         drv_valid = ($urandom % 10) < 7;
         drv_ready = ($urandom % 10) < 7;
         rand_data();
         step();
      end
      drain();
   endtask

   initial begin
      void'($urandom(32'd2024));
      @(negedge clk);
      for (int i = 0; i < 3; i++) @(negedge clk);
      rst_n = 1'b1;
      #1;
      check(rdy_d && rdy_s, "R8 in_ready after reset", {rdy_d, rdy_s}, 2'b11);
      check(!ov_d && !ov_s, "R8 out_valid after reset", {ov_d, ov_s}, 2'b00);
      @(negedge clk);

      // R3: latency of a lone triple, deep copy
      sel = 1'b0; drv_ready = 1'b1;
      drv_valid = 1'b1; drv_a = 32'd3; drv_b = 32'd5; drv_c = 32'd7;
      accepts = 0;
      step();
      check(accepts == 1, "R3 lone triple accepted", accepts, 1);
      drv_valid = 1'b0;
      begin
         int lat = 0;
         for (int i = 1; i <= 40 && lat == 0; i++) begin
            step();
            if (seen_ov) lat = i;
         end
         check(lat == 2 * LAT + 1, "R3 first-result latency", lat, 2 * LAT + 1);
      end
      drain();

      // R1 corner operands
      drv_valid = 1'b1;
      drv_a = '1; drv_b = '1; drv_c = '1; step();
      drv_a = 32'h0001_0000; drv_b = 32'h0001_0000; drv_c = 32'd5; step();
      drv_a = 32'd0; drv_b = 32'hDEAD_BEEF; drv_c = 32'h1234_5678; step();
      drv_a = 32'h8000_0000; drv_b = 32'd1; drv_c = 32'd2; step();
      drv_a = 32'd65535; drv_b = 32'd65537; drv_c = 32'd3; step();
      check(model('1, '1, '1) == 32'hFFFF_FFFF, "R1 all-ones model", model('1, '1, '1), 32'hFFFF_FFFF);
      drain();

      // R4: full rate with a deep forwarding FIFO
      throughput(70, "R4 accepts in 70 cycles");

      // R7: consumer stalled, credits cap the in-flight count
      drv_valid = 1'b1; drv_ready = 1'b0; accepts = 0;
      for (int i = 0; i < 40; i++) begin rand_data(); step(); end
      check(accepts == CRED, "R7 accepts while stalled", accepts, CRED);
      #1;
      check(!rdy_d, "R7 in_ready low at credit limit", rdy_d, 0);
      check(ov_d, "R7 out_valid held while stalled", ov_d, 1);
      @(negedge clk);
      drain();

      random_run(300);

      // R5 / R6: shallow forwarding FIFO limits throughput, results stay correct
      sel = 1'b1;
      throughput(70 * SHORT / LAT, "R5 R6 accepts in 70 cycles, shallow FIFO");
      random_run(300);
      drv_valid = 1'b1; drv_ready = 1'b1; accepts = 0;
      for (int i = 0; i < LAT + 1; i++) begin rand_data(); step(); end
      check(accepts <= SHORT + 1, "R6 R9 fills then waits for first product", accepts, SHORT + 1);
      drain();

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule